// File: doc/BRIEF.md
# Extended Memory Address Mapper with Write Lock

This block turns a 14-bit logical word address into a 15-bit physical word address. Logical addresses in the lower half of the logical space pass through unchanged. Addresses in the upper half take their top octal digit from one of two 3-bit "bank digit" registers. A logical top octal digit of 3 selects the high digit register. A top digit of 2 selects the middle one. The program reloads each register through a load strobe. An initialise pulse, or the reset, returns both registers to the identity mapping.

Each request cycle the block checks the physical address against two things. The first is the installed memory size. A read past the end is flagged so that the data path forces zeros onto it. A write past the end is flagged to be dropped. The second is a lock register. Memory is split into 2048-word blocks, and the first of these blocks is split again into four 512-word pieces. A write into a locked region is dropped and raises a one-cycle interrupt request with a fixed vector. The block also drives two panel lamps and a 10-bit status field that subroutine linkage stores.

Top module: `xmem_mapper`

## Requirements
- R1: When `laddr_i[13]` is 0, `paddr_o` equals `{1'b0, laddr_i}`, whatever the digit registers hold.
- R2: When `laddr_i[13:12]` is 2'b11, `paddr_o` is `{hi_digit, laddr_i[11:0]}`. When it is 2'b10, `paddr_o` is `{mid_digit, laddr_i[11:0]}`.
- R3: The reset (`rst_n` low at a clock edge) or `start_i` high at a clock edge sets hi_digit to 3 and mid_digit to 2 from the next cycle on. `start_i` takes precedence over a load in the same cycle.
- R4: `ld_hi_i` or `ld_mid_i` high at a clock edge copies `ld_val_i` into that digit register, and the new value is used from the next cycle. Without a load or start, a digit register keeps its value.
- R5: A read is a cycle with `req_valid_i`=1 and `req_write_i`=0. `rd_zero_o` is 1 exactly when a read targets a physical address ≥ `mem_words_i`.
- R6: A write is a cycle with `req_valid_i`=1 and `req_write_i`=1. A write to a physical address ≥ `mem_words_i` sets `wr_block_o` and does not raise `prot_irq_o`.
- R7: An in-range write is locked in two cases. Below address 2048 it is locked when `lock_i[paddr[10:9]]` is set. At 2048 and above it is locked when `lock_i[3 + paddr[14:11]]` is set. A locked write sets `wr_block_o` and `prot_irq_o` in that same cycle only.
- R8: Reads never set `wr_block_o` or `prot_irq_o`. `prot_vec_o` is always 6'o35.
- R9: `lamp_hi_o` is 1 whenever hi_digit ≠ 3. `lamp_mid_o` is 1 whenever mid_digit ≠ 2.
- R10: `link_o[0]` is `ovf_i`, `link_o[5:3]` is hi_digit and `link_o[8:6]` is mid_digit. Bits 1, 2 and 9 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Initialise pulse, presets both digit registers |
| ld_hi_i | input | 1 | Load strobe for the high digit register |
| ld_mid_i | input | 1 | Load strobe for the middle digit register |
| ld_val_i | input | 3 | Value to load |
| laddr_i | input | 14 | Logical word address |
| req_valid_i | input | 1 | A memory access is requested this cycle |
| req_write_i | input | 1 | The access is a write |
| mem_words_i | input | 16 | Installed memory size in words |
| lock_i | input | 19 | Lock bits: [3:0] the 512-word pieces, [18:4] blocks 1 to 15 |
| ovf_i | input | 1 | Overflow flag copied into the status field |
| paddr_o | output | 15 | Physical word address |
| rd_zero_o | output | 1 | Force read data to zero |
| wr_block_o | output | 1 | Drop this write |
| prot_irq_o | output | 1 | Protection-violation interrupt request |
| prot_vec_o | output | 6 | Interrupt vector for the violation |
| lamp_hi_o | output | 1 | High digit register is off its preset |
| lamp_mid_o | output | 1 | Middle digit register is off its preset |
| link_o | output | 10 | Status field for subroutine linkage |

## Verification
The assertions assume that `mem_words_i` never exceeds 32768 and that `rst_n` is held low through the first clock edge. The stimulus keeps to both limits. It draws the memory size only from bank-sized values, and it starts every run with several reset cycles. The stimulus also concentrates addresses near block and piece edges and near the installed-size limit. Start and load strobes are sometimes raised together, so that the precedence between them is exercised.

// File: rtl/xmem_pkg.sv
// Shared constants and types for the extended memory address mapper.
package xmem_pkg;
    localparam int LADDR_W  = 14;                      // logical address width
    localparam int EXT_W    = 3;                       // one octal bank digit
    localparam int OFS_W    = LADDR_W - 2;             // bits kept below the digit
    localparam int PADDR_W  = OFS_W + EXT_W;           // physical address width
    localparam int SIZE_W   = PADDR_W + 1;             // installed-size width
    localparam int BLK_SH   = 11;                      // 2048-word blocks
    localparam int SUB_SH   = 9;                       // 512-word pieces
    localparam int NUM_SUB  = 1 << (BLK_SH - SUB_SH);  // pieces in block 0
    localparam int NUM_BLK  = 1 << (PADDR_W - BLK_SH); // blocks in total
    localparam int LOCK_W   = NUM_SUB + NUM_BLK - 1;   // lock register width
    localparam int VEC_W    = 6;
    localparam logic [VEC_W-1:0] PROT_VEC = 6'o35;
    localparam logic [EXT_W-1:0] HI_INIT  = 3'd3;
    localparam logic [EXT_W-1:0] MID_INIT = 3'd2;
    localparam int LINK_W   = 10;

    // Source of the physical top digit.
    typedef enum logic [1:0] {
        SEL_DIRECT = 2'd0,
        SEL_MID    = 2'd1,
        SEL_HI     = 2'd2
    } digit_sel_e;
endpackage

// File: rtl/xmem_digit_reg.sv
// One bank digit register. It presets to INIT on reset or start, loads on
// its strobe, and otherwise holds its value. Assumes start outranks load.
module xmem_digit_reg #(
    parameter int               W    = 3,
    parameter logic [W-1:0]     INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         lamp_o
);
    logic [W-1:0] q_r;

    // Digit storage: reset and start preset, load captures, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) q_r <= INIT;
        else if (ld_i)         q_r <= d_i;
    end

    // Lamp lights whenever the digit is off its preset.
    always_comb lamp_o = (q_r != INIT);

    assign q_o = q_r;

    AST_START_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q_o == INIT)); // R3
    AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !ld_i) |=> $stable(q_o)); // R4
    AST_DIGIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && ld_i) |=> (q_o == $past(d_i))); // R4
    AST_LAMP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !lamp_o); // R9
endmodule

// File: rtl/xmem_addr_xlate.sv
// Address translation. The two top logical bits choose a pass-through or
// one of two bank digits, which replace those bits as the top octal digit.
module xmem_addr_xlate
    import xmem_pkg::*;
#(
    parameter int LW = LADDR_W,
    parameter int EW = EXT_W,
    parameter int PW = PADDR_W
) (
    input  logic [LW-1:0] laddr_i,
    input  logic [EW-1:0] hi_i,
    input  logic [EW-1:0] mid_i,
    output digit_sel_e    sel_o,
    output logic [PW-1:0] paddr_o
);
    localparam int OW = LW - 2;

    // Digit source decode from the two top logical bits.
    always_comb begin
        if (!laddr_i[LW-1])     sel_o = SEL_DIRECT;
        else if (laddr_i[LW-2]) sel_o = SEL_HI;
        else                    sel_o = SEL_MID;
    end

    // Physical address assembly from the chosen source.
    always_comb begin
        case (sel_o)
            SEL_HI:  paddr_o = {hi_i,  laddr_i[OW-1:0]};
            SEL_MID: paddr_o = {mid_i, laddr_i[OW-1:0]};
            default: paddr_o = PW'(laddr_i);
        endcase
    end
endmodule

// File: rtl/xmem_lock_check.sv
// Lock lookup with uneven granularity. Block 0 uses one lock bit per
// 512-word piece; every other 2048-word block has a single bit.
module xmem_lock_check
    import xmem_pkg::*;
#(
    parameter int PW  = PADDR_W,
    parameter int BSH = BLK_SH,
    parameter int SSH = SUB_SH,
    parameter int NLK = LOCK_W
) (
    input  logic [PW-1:0]  paddr_i,
    input  logic [NLK-1:0] lock_i,
    output logic           locked_o
);
    localparam int BW   = PW - BSH;
    localparam int SW   = BSH - SSH;
    localparam int NSUB = 1 << SW;
    localparam int IW   = $clog2(NLK);

    logic [BW-1:0] blk;
    logic [SW-1:0] sub;
    logic [IW-1:0] idx;

    // Lock bit index: piece number in block 0, else offset block number.
    always_comb begin
        blk = paddr_i[PW-1:BSH];
        sub = paddr_i[BSH-1:SSH];
        if (blk == '0) idx = IW'(sub);
        else           idx = IW'(NSUB - 1) + IW'(blk);
    end

    // Pick the lock bit for that index.
    always_comb locked_o = lock_i[idx];
endmodule

// File: rtl/xmem_mapper.sv
// Top level of the extended memory mapper. It holds two bank digit
// registers and translates each logical address. It flags reads beyond
// installed memory for zero data, and drops out-of-range or locked writes;
// a locked in-range write raises a one-cycle protection request.
// Assumes mem_words_i <= 2**PADDR_W.
module xmem_mapper
    import xmem_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               ld_hi_i,
    input  logic               ld_mid_i,
    input  logic [EXT_W-1:0]   ld_val_i,
    input  logic [LADDR_W-1:0] laddr_i,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [SIZE_W-1:0]  mem_words_i,
    input  logic [LOCK_W-1:0]  lock_i,
    input  logic               ovf_i,
    output logic [PADDR_W-1:0] paddr_o,
    output logic               rd_zero_o,
    output logic               wr_block_o,
    output logic               prot_irq_o,
    output logic [VEC_W-1:0]   prot_vec_o,
    output logic               lamp_hi_o,
    output logic               lamp_mid_o,
    output logic [LINK_W-1:0]  link_o
);
    localparam int NREG = 2;
    localparam logic [NREG*EXT_W-1:0] INITS = {MID_INIT, HI_INIT};

    logic [EXT_W-1:0] digit [NREG];
    logic [NREG-1:0]  ld_vec;
    logic [NREG-1:0]  lamp;
    digit_sel_e       sel;
    logic             locked;
    logic             oor;
    logic             is_rd;
    logic             is_wr;

    assign ld_vec = {ld_mid_i, ld_hi_i};

    // Index 0 holds the high digit, index 1 the middle digit.
    for (genvar g = 0; g < NREG; g++) begin : g_digit
        xmem_digit_reg #(
            .W    (EXT_W),
            .INIT (INITS[g*EXT_W +: EXT_W])
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start_i),
            .ld_i    (ld_vec[g]),
            .d_i     (ld_val_i),
            .q_o     (digit[g]),
            .lamp_o  (lamp[g])
        );
    end

    xmem_addr_xlate u_xlate (
        .laddr_i (laddr_i),
        .hi_i    (digit[0]),
        .mid_i   (digit[1]),
        .sel_o   (sel),
        .paddr_o (paddr_o)
    );

    xmem_lock_check u_lock (
        .paddr_i  (paddr_o),
        .lock_i   (lock_i),
        .locked_o (locked)
    );

    // Request classification and range test against installed size.
    always_comb begin
        is_rd = req_valid_i && !req_write_i;
        is_wr = req_valid_i &&  req_write_i;
        oor   = ({1'b0, paddr_o} >= mem_words_i);
    end

    // Access outcome flags.
    always_comb begin
        rd_zero_o  = is_rd && oor;
        wr_block_o = is_wr && (oor || locked);
        prot_irq_o = is_wr && !oor && locked;
        prot_vec_o = PROT_VEC;
    end

    // Panel lamps and linkage status field.
    always_comb begin
        lamp_hi_o  = lamp[0];
        lamp_mid_o = lamp[1];
        link_o     = '0;
        link_o[0]  = ovf_i;
        link_o[5:3] = digit[0];
        link_o[8:6] = digit[1];
    end

    AST_LOW_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        !laddr_i[LADDR_W-1] |-> (paddr_o[OFS_W-1:0] == laddr_i[OFS_W-1:0]) && (sel == SEL_DIRECT)); // R1
    AST_HI_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        (laddr_i[LADDR_W-1:LADDR_W-2] == 2'b11) |-> (paddr_o[PADDR_W-1:OFS_W] == link_o[5:3])); // R2
    AST_OOR_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && oor) |-> (wr_block_o && !prot_irq_o)); // R6
    AST_IRQ_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_irq_o |-> (wr_block_o && req_write_i)); // R7
    AST_READ_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !req_write_i |-> (!wr_block_o && !prot_irq_o)); // R8
    AST_RDZERO_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero_o |-> (req_valid_i && !req_write_i)); // R5
endmodule

// File: tb/xmem_mapper_tb.sv
// Bench for xmem_mapper: a behavioural reference model updated each clock
// and compared against every output, once per cycle, before the clock edge.
module xmem_mapper_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, ld_hi_i = 1'b0, ld_mid_i = 1'b0;
    logic [2:0]  ld_val_i = '0;
    logic [13:0] laddr_i = '0;
    logic        req_valid_i = 1'b0, req_write_i = 1'b0;
    logic [15:0] mem_words_i = 16'd16384;
    logic [18:0] lock_i = '0;
    logic        ovf_i = 1'b0;
    logic [14:0] paddr_o;
    logic        rd_zero_o, wr_block_o, prot_irq_o, lamp_hi_o, lamp_mid_o;
    logic [5:0]  prot_vec_o;
    logic [9:0]  link_o;

    int n_cmp = 0, n_bad = 0;
    int m_hi = 3, m_mid = 2;
    bit model_valid = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    xmem_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ld_hi_i(ld_hi_i),
        .ld_mid_i(ld_mid_i), .ld_val_i(ld_val_i), .laddr_i(laddr_i),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i),
        .mem_words_i(mem_words_i), .lock_i(lock_i), .ovf_i(ovf_i),
        .paddr_o(paddr_o), .rd_zero_o(rd_zero_o), .wr_block_o(wr_block_o),
        .prot_irq_o(prot_irq_o), .prot_vec_o(prot_vec_o),
        .lamp_hi_o(lamp_hi_o), .lamp_mid_o(lamp_mid_o), .link_o(link_o)
    );

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0h expected %0h", req, $time, got, exp);
        end
    endtask

    // Compare all outputs against the model for the present inputs.
    task automatic compare();
        int p, oor, lk, idx, rd, wr;
        if (laddr_i[13] == 1'b0)   p = int'(laddr_i);
        else if (laddr_i[12])      p = m_hi  * 4096 + int'(laddr_i[11:0]);
        else                       p = m_mid * 4096 + int'(laddr_i[11:0]);
        oor = (p >= int'(mem_words_i)) ? 1 : 0;
        if (p < 2048) idx = p / 512;
        else          idx = 3 + p / 2048;
        lk = int'(lock_i[idx]);
        rd = (req_valid_i && !req_write_i) ? 1 : 0;
        wr = (req_valid_i && req_write_i) ? 1 : 0;
        if (laddr_i[13] == 1'b0) check("R1 paddr", int'(paddr_o), p);
        else                     check("R2 paddr", int'(paddr_o), p);
        check("R5 rd_zero", int'(rd_zero_o), rd & oor);
        if (oor != 0) check("R6 wr_block", int'(wr_block_o), wr);
        else          check("R7 wr_block", int'(wr_block_o), wr & lk);
        if (rd != 0)  check("R8 prot_irq", int'(prot_irq_o), 0);
        else          check("R7 prot_irq", int'(prot_irq_o), wr & (1 - oor) & lk);
        check("R8 prot_vec", int'(prot_vec_o), 'o35);
        check("R9 lamp_hi", int'(lamp_hi_o), (m_hi != 3) ? 1 : 0);
        check("R9 lamp_mid", int'(lamp_mid_o), (m_mid != 2) ? 1 : 0);
        check("R10 link", int'(link_o), int'(ovf_i) + m_hi * 8 + m_mid * 64);
        check("R3 R4 digits", int'(link_o[8:3]), m_mid * 8 + m_hi);
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input bit rs, input bit st, input bit lh, input bit lm,
                        input int lv, input int la, input bit v, input bit w,
                        input int mw, input int lck, input bit ov);
        @(negedge clk);
        rst_n = rs; start_i = st; ld_hi_i = lh; ld_mid_i = lm;
        ld_val_i = 3'(lv); laddr_i = 14'(la); req_valid_i = v;
        req_write_i = w; mem_words_i = 16'(mw); lock_i = 19'(lck); ovf_i = ov;
        #1;
        if (model_valid) compare();
        @(posedge clk);
        if (!rs || st) begin m_hi = 3; m_mid = 2; end
        else begin
            if (lh) m_hi = lv;
            if (lm) m_mid = lv;
        end
        model_valid = 1;
    endtask

    initial begin
        // reset state (R3)
        step(0, 0, 1, 1, 5, 0, 0, 0, 16384, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 16384, 0, 0);
        step(1, 0, 0, 0, 0, 'o37777, 1, 0, 16384, 0, 1);
        // identity mapping after reset (R1, R2)
        step(1, 0, 0, 0, 0, 'o23300, 1, 0, 16384, 0, 0);
        // load EM digits (R4), then use them (R2)
        step(1, 0, 0, 1, 4, 0, 0, 0, 32768, 0, 0);
        step(1, 0, 1, 0, 5, 'o23300, 1, 0, 32768, 0, 0);
        step(1, 0, 0, 0, 0, 'o34000, 1, 0, 32768, 0, 0);
        step(1, 0, 0, 1, 7, 'o17777, 1, 0, 32768, 0, 0);
        step(1, 0, 0, 0, 0, 'o23300, 1, 1, 32768, 0, 1);
        // out of range read and write (R5, R6), lock set everywhere
        step(1, 0, 0, 0, 0, 'o23300, 1, 0, 16384, 'h7FFFF, 0);
        step(1, 0, 0, 0, 0, 'o23300, 1, 1, 16384, 'h7FFFF, 0);
        // start beats a load (R3)
        step(1, 1, 1, 1, 6, 'o34000, 0, 0, 32768, 0, 0);
        step(1, 0, 0, 0, 0, 'o34000, 1, 0, 32768, 0, 0);
        // piece and block lock edges (R7)
        step(1, 0, 0, 0, 0, 511, 1, 1, 32768, 'h1, 0);
        step(1, 0, 0, 0, 0, 512, 1, 1, 32768, 'h1, 0);
        step(1, 0, 0, 0, 0, 2047, 1, 1, 32768, 'h8, 0);
        step(1, 0, 0, 0, 0, 2048, 1, 1, 32768, 'h10, 0);
        step(1, 0, 0, 0, 0, 2048, 1, 0, 32768, 'h10, 0);
        step(1, 0, 0, 0, 0, 4095, 1, 1, 4096, 'h10, 0);
        step(1, 0, 0, 0, 0, 4096, 1, 1, 4096, 'h20, 0);
        // random traffic near edges
        for (int i = 0; i < 4000; i++) begin
            int la, mw, r;
            r = int'($urandom_range(0, 3));
            case (r)
                0: mw = 4096;
                1: mw = 8192;
                2: mw = 16384;
                default: mw = 32768;
            endcase
            la = int'($urandom_range(0, 16383));
            if ($urandom_range(0, 3) == 0) la = (la & 'o34000) | ($urandom_range(0, 1) ? 'o3777 : 0);
            step(($urandom_range(0, 199) != 0), ($urandom_range(0, 49) == 0),
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                 int'($urandom_range(0, 7)), la, $urandom_range(0, 3) != 0,
                 $urandom_range(0, 1) == 1, mw,
                 ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 'h7FFFF)),
                 $urandom_range(0, 1) == 1);
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule